// File: doc/BRIEF.md
# Alternating-Clock Byte Deserializer

This block recovers bytes from a two-wire link where neither wire is a dedicated clock. The two wires take turns. When wire A falls, the level on wire B is the next bit. When wire B falls, the level on wire A is the next bit. Eight bits, most significant first, form one byte, carried as four A-then-B edge pairs. The block watches the strict turn-taking of the two wires. An edge out of turn is reported as a framing error and ends the frame. A short closing pattern is reported as the end of the frame.

The inputs are line samples that are already synchronized to `clk`, and an `enable` from an upstream start-pattern detector. `enable` is high for as long as a frame may be in progress. Dropping `enable` abandons whatever has been gathered. Raising it again starts a clean byte.

The byte output is a valid-only stream. It has no ready input, because the sender on the wires cannot be held off, so there is no back-pressure at all. The consumer must take `byte_data` in the single cycle that `byte_valid` is high. `byte_data` then holds its value until the next byte is issued. Checksums and the meaning of fields belong to later stages.

Top module: `alt_deser_rx`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `byte_valid`, `end_seen` and `frame_err` are 0.
- R2: An A fall samples B and a B fall samples A. Bits fill a shift register, most significant first. A falls carry bits 7, 5, 3, 1 and B falls carry bits 6, 4, 2, 0. Each issued byte pulses `byte_valid` for exactly one cycle.
- R3: After the fourth B fall, the byte is held until wire A is seen high. It is issued on the next clock after that sample, and never while A stays low.
- R4: Before the first bit of a byte, one B fall with A high is accepted as a start marker. A second such fall in the same byte is a framing error.
- R5: A framing error pulses `frame_err` for one cycle. The following edges count as framing errors:
  - an A fall when the A and B counts differ, other than the case in R6;
  - a B fall when the A count is not one ahead of the B count, other than the start marker;
  - A and B falling in the same sample.
  After a framing error, no byte, end or further error is reported until `enable` has gone low and high again.
- R6: Wire levels in this pattern are 1 for high and 0 for low. The end pattern starts when the first A fall of a byte samples 0. It is followed by a second A fall with B at 0, before any B fall. The end pattern is then completed by both wires being high in the same sample, which pulses `end_seen`. Any fall on either wire before that point is a framing error.
- R7: While `enable` is low, no output pulse is produced and wire activity is ignored. Raising `enable` starts a byte with both counts, the shift register and the marker allowance cleared.
- R8: Counts and data clear at the start of each byte, so bytes can follow back to back. A B fall in the same sample that releases a byte (A seen high) is taken as the start marker of the next byte.
- R9: `byte_valid`, `end_seen` and `frame_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Frame in progress, from the start-pattern detector |
| line_a | input | 1 | Synchronized sample of wire A |
| line_b | input | 1 | Synchronized sample of wire B |
| byte_data | output | DATA_W | Last issued byte |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| end_seen | output | 1 | One-cycle pulse on a complete end pattern |
| frame_err | output | 1 | One-cycle pulse on a turn-taking violation |

## Verification
Releasing a finished byte and accepting the start marker of the next byte can fall in one cycle. This happens when wire A rises while wire B falls. The bench provokes it by holding A low after the fourth B fall, raising B, and then moving both wires in a single sample. It judges the result in two ways. In one run, both bytes must arrive intact with no error. In a second run, one more marker fall must be rejected as a framing error, which shows that the shared-cycle fall used up the marker allowance.

// File: rtl/alt_deser_pkg.sv
package alt_deser_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BYTE  = 3'd1,
    ST_DRAIN = 3'd2,
    ST_TAIL  = 3'd3,
    ST_HALT  = 3'd4
  } rx_state_t;
endpackage

// File: rtl/alt_deser_edge.sv
module alt_deser_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] fall
);
  // idle wires rest high, so the history starts high
  for (genvar gi = 0; gi < N; gi++) begin : g_line
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= lvl[gi];
    end
    assign fall[gi] = prev_q & ~lvl[gi];
  end
endmodule

// File: rtl/alt_deser_shift.sv
module alt_deser_shift #(
  parameter int DATA_W = 8,
  localparam int PAIRS = DATA_W / 2,
  localparam int CW    = $clog2(PAIRS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take_a,
  input  logic              take_b,
  input  logic              take_mark,
  input  logic              bit_in,
  output logic [CW-1:0]     cnt_a,
  output logic [CW-1:0]     cnt_b,
  output logic [DATA_W-1:0] data,
  output logic              first
);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_a <= '0;
      cnt_b <= '0;
      data  <= '0;
      first <= 1'b1;
    end else if (clr) begin
      cnt_a <= '0;
      cnt_b <= '0;
      data  <= '0;
      first <= ~take_mark;
    end else begin
      if (take_a || take_b) data <= {data[DATA_W-2:0], bit_in};
      if (take_a) cnt_a <= cnt_a + ONE;
      if (take_b) cnt_b <= cnt_b + ONE;
      if (take_mark) first <= 1'b0;
    end
  end

  AST_CNT_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_a == cnt_b) || (cnt_a == cnt_b + ONE)); // R2
  AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_a && take_b)); // R5
endmodule

// File: rtl/alt_deser_rx.sv
module alt_deser_rx
  import alt_deser_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              line_a,
  input  logic              line_b,
  output logic [DATA_W-1:0] byte_data,
  output logic              byte_valid,
  output logic              end_seen,
  output logic              frame_err
);
  localparam int PAIRS = DATA_W / 2;
  localparam int CW    = $clog2(PAIRS + 1);
  localparam logic [CW-1:0] ONE    = CW'(1);
  localparam logic [CW-1:0] LAST_B = CW'(PAIRS - 1);

  rx_state_t state, nxt;
  logic [1:0] fall;
  logic fa, fb;
  logic [CW-1:0] cnt_a, cnt_b;
  logic [DATA_W-1:0] data;
  logic first;
  logic clr, take_a, take_b, take_mark, bit_in;
  logic ev_issue, ev_end, ev_err;
  logic tail_ok;

  alt_deser_edge #(.N(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  ({line_b, line_a}),
    .fall (fall)
  );
  assign fa = fall[0];
  assign fb = fall[1];

  alt_deser_shift #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .take_a   (take_a),
    .take_b   (take_b),
    .take_mark(take_mark),
    .bit_in   (bit_in),
    .cnt_a    (cnt_a),
    .cnt_b    (cnt_b),
    .data     (data),
    .first    (first)
  );

  // a second A fall right after a lone zero bit, with B low, opens the end check
  assign tail_ok = (cnt_a == ONE) && (cnt_b == '0) && (data == '0) && !line_b;

  always_comb begin
    nxt       = state;
    clr       = 1'b0;
    take_a    = 1'b0;
    take_b    = 1'b0;
    take_mark = 1'b0;
    bit_in    = 1'b0;
    ev_issue  = 1'b0;
    ev_end    = 1'b0;
    ev_err    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (enable) begin
          clr = 1'b1;
          nxt = ST_BYTE;
        end
      end
      ST_BYTE: begin
        if (fa && fb) begin
          ev_err = 1'b1;
        end else if (fa) begin
          if (cnt_a == cnt_b) begin
            take_a = 1'b1;
            bit_in = line_b;
          end else if (tail_ok) begin
            nxt = ST_TAIL;
          end else begin
            ev_err = 1'b1;
          end
        end else if (fb) begin
          if (cnt_a == cnt_b + ONE) begin
            take_b = 1'b1;
            bit_in = line_a;
            if (cnt_b == LAST_B) nxt = ST_DRAIN;
          end else if ((cnt_a == '0) && (cnt_b == '0) && first && line_a) begin
            take_mark = 1'b1;
          end else begin
            ev_err = 1'b1;
          end
        end
      end
      ST_DRAIN: begin
        if (line_a) begin
          ev_issue  = 1'b1;
          clr       = 1'b1;
          take_mark = fb;
          nxt       = ST_BYTE;
        end
      end
      ST_TAIL: begin
        if (line_a && line_b) begin
          ev_end = 1'b1;
          nxt    = ST_HALT;
        end else if (fa || fb) begin
          ev_err = 1'b1;
        end
      end
      default: ;
    endcase
    if (ev_err) nxt = ST_HALT;
    if (!enable) begin
      nxt      = ST_IDLE;
      ev_issue = 1'b0;
      ev_end   = 1'b0;
      ev_err   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      byte_data  <= '0;
      byte_valid <= 1'b0;
      end_seen   <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      state      <= nxt;
      byte_valid <= ev_issue;
      end_seen   <= ev_end;
      frame_err  <= ev_err;
      if (ev_issue) byte_data <= data;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid); // R2
  AST_ISSUE_A_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(line_a)); // R3
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !byte_valid && !end_seen && !frame_err); // R5
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !(byte_valid || end_seen || frame_err)); // R7
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_valid, end_seen, frame_err})); // R9
endmodule

// File: tb/alt_deser_rx_tb.sv
module alt_deser_rx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic la = 1'b1;
  logic lb = 1'b1;
  logic [7:0] byte_data;
  logic byte_valid, end_seen, frame_err;

  int total = 0;
  int bad = 0;
  int nb = 0;
  int ne = 0;
  int nf = 0;
  int multi = 0;
  logic [7:0] got [0:31];

  always #10 clk = ~clk;

  alt_deser_rx #(.DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .line_a(la), .line_b(lb),
    .byte_data(byte_data), .byte_valid(byte_valid),
    .end_seen(end_seen), .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid) begin
        if (nb < 32) got[nb] = byte_data;
        nb = nb + 1;
      end
      if (end_seen) ne = ne + 1;
      if (frame_err) nf = nf + 1;
      if (32'(byte_valid) + 32'(end_seen) + 32'(frame_err) > 1) multi = multi + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic b);
    @(negedge clk);
    la = a;
    lb = b;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    #2;
  endtask

  task automatic restart();
    step(1'b1, 1'b1);
    enable = 1'b0;
    repeat (3) step(1'b1, 1'b1);
    enable = 1'b1;
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
  endtask

  // four A/B pairs, MSB first; leaves A at bit 0 level
  task automatic send_bits(input logic [7:0] v, input bit marker);
    if (marker) begin
      step(1'b1, 1'b1);
      step(1'b1, 1'b0);
    end
    for (int i = 3; i >= 0; i--) begin
      step(1'b1, v[2*i+1]);
      step(1'b0, v[2*i+1]);
      step(v[2*i], 1'b1);
      step(v[2*i], 1'b0);
    end
  endtask

  task automatic t_reset();
    #5;
    chk(!byte_valid && !end_seen && !frame_err, "R1 in reset", {byte_valid, end_seen, frame_err}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk(!byte_valid && !end_seen && !frame_err, "R1 after reset", {byte_valid, end_seen, frame_err}, 0);
  endtask

  task automatic t_basic();
    int b0;
    restart();
    b0 = nb;
    send_bits(8'hA5, 1'b0);
    step(1'b1, 1'b1);
    settle();
    chk(nb == b0 + 1 && got[b0] == 8'hA5, "R2 byte A5", got[b0], 8'hA5);
    send_bits(8'h00, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    settle();
    chk(nb == b0 + 2 && got[b0+1] == 8'h00, "R8 second byte 00", got[b0+1], 8'h00);
    chk(nf == 0, "R2 no error on clean bytes", nf, 0);
  endtask

  task automatic t_drain();
    int b0;
    restart();
    b0 = nb;
    send_bits(8'h3C, 1'b1);
    repeat (5) step(1'b0, 1'b0);
    #2;
    chk(nb == b0, "R3 held while A low", nb - b0, 0);
    step(1'b1, 1'b0);
    settle();
    chk(nb == b0 + 1 && got[b0] == 8'h3C, "R3 byte 3C after A high", got[b0], 8'h3C);
    chk(nf == 0, "R4 single marker accepted", nf, 0);
  endtask

  task automatic t_marker2();
    int f0;
    restart();
    f0 = nf;
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    settle();
    chk(nf == f0 + 1, "R4 second marker rejected", nf - f0, 1);
  endtask

  task automatic t_order();
    int f0, b0;
    restart();
    f0 = nf;
    b0 = nb;
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    settle();
    chk(nf == f0 + 1, "R5 double A edge", nf - f0, 1);
    step(1'b1, 1'b1);
    send_bits(8'hC3, 1'b0);
    step(1'b1, 1'b1);
    settle();
    chk(nb == b0 && nf == f0 + 1, "R5 frame abandoned", nb - b0, 0);
    restart();
    f0 = nf;
    step(1'b0, 1'b0);
    settle();
    chk(nf == f0 + 1, "R5 simultaneous falls", nf - f0, 1);
    restart();
    f0 = nf;
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    settle();
    chk(nf == f0 + 1, "R5 double B edge", nf - f0, 1);
  endtask

  task automatic t_end();
    int e0, b0, f0;
    restart();
    e0 = ne;
    b0 = nb;
    f0 = nf;
    send_bits(8'h5A, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    settle();
    chk(nb == b0 + 1 && got[b0] == 8'h5A, "R6 byte before end", got[b0], 8'h5A);
    chk(ne == e0 + 1 && nf == f0, "R6 end pattern", ne - e0, 1);
    restart();
    e0 = ne;
    f0 = nf;
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    settle();
    chk(ne == e0 && nf == f0 + 1, "R6 fall during end check", nf - f0, 1);
  endtask

  task automatic t_enable();
    int b0, f0;
    restart();
    b0 = nb;
    f0 = nf;
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    enable = 1'b0;
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    settle();
    chk(nf == f0 && nb == b0, "R7 ignored while disabled", nf - f0, 0);
    step(1'b1, 1'b1);
    enable = 1'b1;
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    send_bits(8'hC3, 1'b0);
    step(1'b1, 1'b1);
    settle();
    chk(nb == b0 + 1 && got[b0] == 8'hC3, "R7 clean byte after re-enable", got[b0], 8'hC3);
  endtask

  task automatic t_same();
    int b0, f0;
    restart();
    b0 = nb;
    f0 = nf;
    send_bits(8'h96, 1'b0);
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    send_bits(8'h81, 1'b0);
    step(1'b1, 1'b1);
    settle();
    chk(nb == b0 + 2 && got[b0] == 8'h96 && got[b0+1] == 8'h81 && nf == f0,
        "R8 issue with marker", {got[b0], got[b0+1]}, 16'h9681);
    restart();
    f0 = nf;
    send_bits(8'h96, 1'b0);
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    settle();
    chk(nf == f0 + 1, "R8 shared-cycle marker consumed", nf - f0, 1);
  endtask

  initial begin
    #4_000_000;
    total = total + 1;
    bad = bad + 1;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_drain();
    t_marker2();
    t_order();
    t_end();
    t_enable();
    t_same();
    chk(multi == 0, "R9 exclusive pulses", multi, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule